// File: doc/BRIEF.md
# Dual-Issue Register Scoreboard

This block sits between the decoder and the execution units of a two-wide superscalar core and decides, every cycle, which entries of a small lookahead window of decoded instructions may be sent to execution. Each window entry holds a valid flag, two source register indices and one destination register index. For each of the eight architectural registers, the block keeps one counter of issued but unfinished instructions that read the register and another of those that write it. It grants up to two entries per cycle. These grants may bypass older entries that stall.

Bypassing an older entry is made safe by a bitmap that is rebuilt every cycle. For each register, it holds one bit set when an older entry that was examined and held back writes that register. The same pass also tracks the sources of the held-back entries. A younger entry that would read or overwrite such a register, or overwrite a value that the held-back entry still has to read, is held back too. A completion port returns the register indices of a finished instruction and releases its counters. The caller removes granted entries from its window before the next cycle.

Top module: `issueScoreboard`

## Requirements
- R1: `issueMask` bit i answers window slot i, and slot 0 is the oldest. A slot whose `winValid` bit is 0 is never granted and never contributes to `skipMap`.
- R2: At most two slots are granted per cycle. When more slots are eligible, the two oldest eligible slots are granted.
- R3: A slot is held back while either of its source registers has a nonzero writer count (read after write).
- R4: A slot is held back while its destination register has a nonzero reader count or a nonzero writer count (write after read, write after write).
- R5: A younger slot may be granted while an older valid slot is held back, provided none of the rules here blocks it.
- R6: `skipMap` bit r is 1 exactly when some valid slot that is not granted this cycle has destination r.
- R7: A slot is held back if either of its sources or its destination equals the destination of an older held-back valid slot. It is also held back if its destination equals a source of an older held-back valid slot.
- R8: The second slot granted in a cycle is held back if either of its sources equals the first granted slot's destination. It is also held back if its destination equals the first slot's destination or either of the first slot's sources.
- R9: On a grant, the reader count of each distinct register the slot reads rises by one, so a slot with equal sources counts once. The writer count of its destination also rises by one. A completion lowers the same counters in the same way. Issue and completion that touch one register in the same cycle both take effect.
- R10: A slot is held back while the reader count of either of its sources is at or above 2^CNT_W - 2, so a reader count never wraps.
- R11: Reset clears every counter. Right after reset, the two oldest valid slots that do not conflict with each other are granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winValid | input | WIN | Slot holds a decoded instruction |
| winSrcA | input | WIN x 3 | First source register per slot |
| winSrcB | input | WIN x 3 | Second source register per slot |
| winDst | input | WIN x 3 | Destination register per slot |
| doneValid | input | 1 | A previously issued instruction finishes this cycle |
| doneSrcA | input | 3 | First source of the finishing instruction |
| doneSrcB | input | 3 | Second source of the finishing instruction |
| doneDst | input | 3 | Destination of the finishing instruction |
| issueMask | output | WIN | Per-slot grant for this cycle |
| skipMap | output | 8 | Destinations of valid slots held back this cycle |

## Verification
A grant and a completion can fall in the same cycle, and both can touch the same register counter. That is the case where a lost increment or decrement stays hidden until a later hazard decision goes wrong. The bench removes a randomly chosen in-flight instruction on about half of all cycles while new grants continue. Because the sources and destinations are drawn from only eight registers, many completions land on a register that the same cycle's grant also bumps. The result is judged from the grant mask and the bitmap of every following cycle, compared against a behavioural model that keeps its own counts.

// File: rtl/sbPkg.sv
package sbPkg;
  parameter int SB_REGS = 8;
  localparam int SB_RW = $clog2(SB_REGS);

  // Per-register strobes from the issue control to the counter datapath
  typedef struct packed {
    logic [SB_REGS-1:0] rdFirst;   // registers read by the first grant
    logic [SB_REGS-1:0] rdSecond;  // registers read by the second grant
    logic [SB_REGS-1:0] wrMark;    // destinations of both grants
  } issueStrobe_t;

  function automatic logic [SB_REGS-1:0] regBit(input logic [SB_RW-1:0] r);
    return SB_REGS'(1) << r;
  endfunction
endpackage

// File: rtl/sbCounters.sv
module sbCounters
  import sbPkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  issueStrobe_t                      strobe,
  input  logic                              doneValid,
  input  logic [SB_RW-1:0]                  doneSrcA,
  input  logic [SB_RW-1:0]                  doneSrcB,
  input  logic [SB_RW-1:0]                  doneDst,
  output logic [SB_REGS-1:0][CNT_W-1:0]     rdCnt,
  output logic [SB_REGS-1:0][CNT_W-1:0]     wrCnt
);

  for (genvar r = 0; r < SB_REGS; r++) begin : g_reg
    logic [1:0] rdUp;
    logic       rdDown;
    logic       wrUp;
    logic       wrDown;

    always_comb begin
      rdUp   = {1'b0, strobe.rdFirst[r]} + {1'b0, strobe.rdSecond[r]};
      rdDown = doneValid && (doneSrcA == SB_RW'(r) || doneSrcB == SB_RW'(r));
      wrUp   = strobe.wrMark[r];
      wrDown = doneValid && (doneDst == SB_RW'(r));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdCnt[r] <= '0;
        wrCnt[r] <= '0;
      end else begin
        rdCnt[r] <= rdCnt[r] + CNT_W'(rdUp) - CNT_W'(rdDown);
        wrCnt[r] <= wrCnt[r] + CNT_W'(wrUp) - CNT_W'(wrDown);
      end
    end

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrCnt[r] <= CNT_W'(1));

    // R10
    rd_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rdCnt[r] == '1) |=> (rdCnt[r] != '0));
  end

endmodule

// File: rtl/sbIssueCtrl.sv
module sbIssueCtrl
  import sbPkg::*;
#(
  parameter int WIN   = 4,
  parameter int CNT_W = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [WIN-1:0]                    valid,
  input  logic [WIN-1:0][SB_RW-1:0]         srcA,
  input  logic [WIN-1:0][SB_RW-1:0]         srcB,
  input  logic [WIN-1:0][SB_RW-1:0]         dst,
  input  logic [SB_REGS-1:0][CNT_W-1:0]     rdCnt,
  input  logic [SB_REGS-1:0][CNT_W-1:0]     wrCnt,
  output logic [WIN-1:0]                    grant,
  output logic [SB_REGS-1:0]                skipMap,
  output issueStrobe_t                      strobe
);

  localparam int SAT = (1 << CNT_W) - 2;

  logic [WIN-1:0] ctrHaz;

  // Hazards against in-flight instructions, one per slot
  for (genvar i = 0; i < WIN; i++) begin : g_slot
    always_comb begin
      ctrHaz[i] = (wrCnt[srcA[i]] != '0) || (wrCnt[srcB[i]] != '0)
               || (rdCnt[dst[i]] != '0)  || (wrCnt[dst[i]] != '0)
               || (rdCnt[srcA[i]] >= CNT_W'(SAT))
               || (rdCnt[srcB[i]] >= CNT_W'(SAT));
    end

    // R3
    raw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> (wrCnt[srcA[i]] == '0 && wrCnt[srcB[i]] == '0));

    // R10
    sat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> (rdCnt[srcA[i]] < CNT_W'(SAT) && rdCnt[srcB[i]] < CNT_W'(SAT)));

    // R6
    skip_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
      (valid[i] && !grant[i]) |-> skipMap[dst[i]]);
  end

  logic [SB_REGS-1:0] skipD;
  logic [SB_REGS-1:0] skipS;
  logic [1:0]         nIss;
  logic               haveFirst;
  logic               ok;
  logic [SB_RW-1:0]   fA;
  logic [SB_RW-1:0]   fB;
  logic [SB_RW-1:0]   fD;

  // Oldest-first selection pass
  always_comb begin
    skipD     = '0;
    skipS     = '0;
    nIss      = '0;
    haveFirst = 1'b0;
    ok        = 1'b0;
    fA        = '0;
    fB        = '0;
    fD        = '0;
    grant     = '0;
    strobe    = '0;
    for (int i = 0; i < WIN; i++) begin
      if (valid[i]) begin
        ok = !ctrHaz[i] && (nIss < 2'd2)
          && !skipD[srcA[i]] && !skipD[srcB[i]] && !skipD[dst[i]]
          && !skipS[dst[i]];
        if (haveFirst && (srcA[i] == fD || srcB[i] == fD || dst[i] == fD
                          || dst[i] == fA || dst[i] == fB))
          ok = 1'b0;
        if (ok) begin
          grant[i] = 1'b1;
          strobe.wrMark = strobe.wrMark | regBit(dst[i]);
          if (!haveFirst) begin
            strobe.rdFirst = regBit(srcA[i]) | regBit(srcB[i]);
            fA = srcA[i];
            fB = srcB[i];
            fD = dst[i];
            haveFirst = 1'b1;
          end else begin
            strobe.rdSecond = regBit(srcA[i]) | regBit(srcB[i]);
          end
          nIss = nIss + 2'd1;
        end else begin
          skipD = skipD | regBit(dst[i]);
          skipS = skipS | regBit(srcA[i]) | regBit(srcB[i]);
        end
      end
    end
    skipMap = skipD;
  end

  // R2
  issue_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grant) <= 2);

  // R1
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~valid) == '0);

endmodule

// File: rtl/issueScoreboard.sv
module issueScoreboard
  import sbPkg::*;
#(
  parameter int WIN   = 4,
  parameter int CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WIN-1:0]              winValid,
  input  logic [WIN-1:0][SB_RW-1:0]   winSrcA,
  input  logic [WIN-1:0][SB_RW-1:0]   winSrcB,
  input  logic [WIN-1:0][SB_RW-1:0]   winDst,
  input  logic                        doneValid,
  input  logic [SB_RW-1:0]            doneSrcA,
  input  logic [SB_RW-1:0]            doneSrcB,
  input  logic [SB_RW-1:0]            doneDst,
  output logic [WIN-1:0]              issueMask,
  output logic [SB_REGS-1:0]          skipMap
);

  issueStrobe_t                  strobe;
  logic [SB_REGS-1:0][CNT_W-1:0] rdCnt;
  logic [SB_REGS-1:0][CNT_W-1:0] wrCnt;

  sbIssueCtrl #(.WIN(WIN), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .valid   (winValid),
    .srcA    (winSrcA),
    .srcB    (winSrcB),
    .dst     (winDst),
    .rdCnt   (rdCnt),
    .wrCnt   (wrCnt),
    .grant   (issueMask),
    .skipMap (skipMap),
    .strobe  (strobe)
  );

  sbCounters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .doneValid (doneValid),
    .doneSrcA  (doneSrcA),
    .doneSrcB  (doneSrcB),
    .doneDst   (doneDst),
    .rdCnt     (rdCnt),
    .wrCnt     (wrCnt)
  );

endmodule

// File: tb/issueScoreboard_tb.sv
`timescale 1ns/1ps
module issueScoreboard_tb;
  localparam int WIN = 4;
  localparam int NR  = 8;
  localparam int SAT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIN-1:0]      winValid = '0;
  logic [WIN-1:0][2:0] winSrcA = '0;
  logic [WIN-1:0][2:0] winSrcB = '0;
  logic [WIN-1:0][2:0] winDst = '0;
  logic                doneValid = 1'b0;
  logic [2:0]          doneSrcA = '0;
  logic [2:0]          doneSrcB = '0;
  logic [2:0]          doneDst = '0;
  logic [WIN-1:0]      issueMask;
  logic [NR-1:0]       skipMap;

  always #2.5 clk = ~clk;

  issueScoreboard u_dut (
    .clk(clk), .rstN(rstN),
    .winValid(winValid), .winSrcA(winSrcA), .winSrcB(winSrcB), .winDst(winDst),
    .doneValid(doneValid), .doneSrcA(doneSrcA), .doneSrcB(doneSrcB), .doneDst(doneDst),
    .issueMask(issueMask), .skipMap(skipMap)
  );

  typedef struct { int a; int b; int d; } ins_t;
  ins_t pend[$];
  ins_t fly[$];
  int   rdM[NR];
  int   wrM[NR];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic push(input int a, input int b, input int d);
    ins_t x;
    x.a = a; x.b = b; x.d = d;
    pend.push_back(x);
  endtask

  // One cycle: drive window and completion, compare, then update the model
  task automatic step(input string tag, input int holePct, input int donePct);
    int   slotIdx[WIN];
    int   k;
    int   doneIdx;
    int   expGrant;
    int   expSkip;
    int   nIss;
    int   skipD;
    int   skipS;
    int   fa, fb, fd;
    int   rm[$];
    @(negedge clk);
    k = 0;
    for (int i = 0; i < WIN; i++) begin
      if (k < pend.size() && ($urandom % 100) >= holePct) begin
        winValid[i] = 1'b1;
        winSrcA[i]  = 3'(pend[k].a);
        winSrcB[i]  = 3'(pend[k].b);
        winDst[i]   = 3'(pend[k].d);
        slotIdx[i]  = k;
        k++;
      end else begin
        winValid[i] = 1'b0;
        winSrcA[i]  = 3'($urandom);
        winSrcB[i]  = 3'($urandom);
        winDst[i]   = 3'($urandom);
        slotIdx[i]  = -1;
      end
    end
    doneIdx = -1;
    doneValid = 1'b0;
    if (fly.size() > 0 && ($urandom % 100) < donePct) begin
      doneIdx = int'($urandom % fly.size());
      doneValid = 1'b1;
      doneSrcA = 3'(fly[doneIdx].a);
      doneSrcB = 3'(fly[doneIdx].b);
      doneDst  = 3'(fly[doneIdx].d);
    end
    // behavioural expectation
    expGrant = 0; nIss = 0; skipD = 0; skipS = 0; fa = -1; fb = -1; fd = -1;
    for (int i = 0; i < WIN; i++) begin
      if (slotIdx[i] >= 0) begin
        ins_t x;
        bit ok;
        x = pend[slotIdx[i]];
        ok = 1;
        if (wrM[x.a] != 0 || wrM[x.b] != 0) ok = 0;
        if (rdM[x.d] != 0 || wrM[x.d] != 0) ok = 0;
        if (rdM[x.a] >= SAT || rdM[x.b] >= SAT) ok = 0;
        if (skipD[x.a] || skipD[x.b] || skipD[x.d] || skipS[x.d]) ok = 0;
        if (nIss == 1 && (x.a == fd || x.b == fd || x.d == fd || x.d == fa || x.d == fb)) ok = 0;
        if (nIss >= 2) ok = 0;
        if (ok) begin
          expGrant |= (1 << i);
          if (nIss == 0) begin fa = x.a; fb = x.b; fd = x.d; end
          nIss++;
        end else begin
          skipD |= (1 << x.d);
          skipS |= (1 << x.a) | (1 << x.b);
        end
      end
    end
    #1;
    chk({tag, " grant"}, int'(issueMask), expGrant);
    chk({tag, " skipMap"}, int'(skipMap), expSkip_fix(skipD));
    @(posedge clk);
    for (int i = 0; i < WIN; i++) begin
      if (expGrant[i]) begin
        ins_t x;
        x = pend[slotIdx[i]];
        rdM[x.a]++;
        if (x.b != x.a) rdM[x.b]++;
        wrM[x.d]++;
        fly.push_back(x);
        rm.push_front(slotIdx[i]);
      end
    end
    foreach (rm[j]) pend.delete(rm[j]);
    if (doneIdx >= 0) begin
      ins_t y;
      y = fly[doneIdx];
      rdM[y.a]--;
      if (y.b != y.a) rdM[y.b]--;
      wrM[y.d]--;
      fly.delete(doneIdx);
    end
  endtask

  function automatic int expSkip_fix(input int v);
    return v & ((1 << NR) - 1);
  endfunction

  task automatic drain(input string tag);
    for (int n = 0; n < 300 && (pend.size() > 0 || fly.size() > 0); n++)
      step(tag, 0, 100);
    chk({tag, " drained"}, pend.size() + fly.size(), 0);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin rdM[r] = 0; wrM[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11: nothing valid after reset, bitmap empty
    chk("R11 reset skipMap", int'(skipMap), 0);
    chk("R11 reset grant", int'(issueMask), 0);

    // R11 R2 R6: four independent slots right after reset
    push(0, 1, 3); push(0, 1, 4); push(0, 2, 5); push(1, 2, 6);
    step("R11 R2 R6", 0, 0);
    chk("R2 two oldest issued", pend.size(), 2);
    drain("R9 release");

    // R10: readers of r0 pile up with no completion
    for (int d = 1; d < NR; d++) push(0, 0, d);
    for (int n = 0; n < 6; n++) step("R10 R5", 0, 0);
    chk("R10 saturation holds seventh reader", pend.size(), 1);
    drain("R10 R9 release");

    // R3 R4 R7 R8: a dependent chain with out-of-order grants
    push(0, 1, 3); push(0, 2, 4); push(0, 1, 5); push(1, 4, 6);
    push(1, 2, 7); push(0, 2, 1); push(3, 1, 3); push(4, 4, 1);
    for (int n = 0; n < 40 && (pend.size() > 0); n++) step("R3 R4 R5 R7 R8", 0, 30);
    drain("R9 chain");

    // Mixed random traffic with holes and out-of-order completion
    for (int n = 0; n < 1500; n++) begin
      while (pend.size() < 6)
        push(int'($urandom % NR), int'($urandom % NR), int'($urandom % NR));
      step("R1 R2 R3 R4 R5 R6 R7 R8 R9", 15, 45);
    end
    drain("R9 mixed");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule